// File: doc/BRIEF.md
# Split-Halfword Counter Adjust Unit

This unit updates a machine word that packs a loop count in its upper half and an address in its lower half. The two halves are separate fields. Each is updated with its own 18-bit adder, and no carry ever passes from the address half into the count half. Both halves therefore wrap on their own.

Two operations are offered. The step operation adds one to both halves, which suits an index register that counts up toward zero while it walks an array. It also raises a continue flag while the word is still negative. The adjust operation adds one signed amount to both halves, as when a stack pointer is moved by several slots. It raises a trap when the sign of the word flips.

A caller presents the word, the operation select and the amount together with a valid strobe. The updated word and both flags come back from registers one clock later, marked by a one-cycle valid pulse.

Top module: `halfword_adjust_unit`

## Requirements
- R1: With op_sel = 0 (step), the upper half of the result is the upper half of the operand plus one, and the lower half is the lower half of the operand plus one. Each sum is taken modulo 2^18.
- R2: No carry crosses between the halves. An operand of X in the upper half and all ones in the lower half gives X+1 in the upper half and 0 in the lower half. An upper half of all ones wraps to 0 without affecting the lower half.
- R3: With op_sel = 1 (adjust), the 18-bit amount is added to the lower half and to the upper half separately. Each sum is taken modulo 2^18, and no carry passes between the halves.
- R4: The amount is an 18-bit two's-complement value, so a negative amount decreases both halves. For example, an amount of all ones subtracts one from each half.
- R5: In adjust mode, trap_ovf is 1 exactly when bit 35 (the word sign) of the result differs from bit 35 of the operand. In step mode, trap_ovf is 0.
- R6: In step mode, loop_go equals bit 35 of the result. In adjust mode, loop_go is 0.
- R7: out_valid is 1 in the cycle after a cycle with in_valid = 1, and 0 otherwise. result, loop_go and trap_ovf are valid in that same cycle.
- R8: In a cycle without in_valid, result, loop_go and trap_ovf keep their previous values.
- R9: A synchronous active-high reset clears result, loop_go, trap_ovf and out_valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 1 | 0 = step both halves, 1 = adjust by amount |
| operand | input | 36 | Word: count in bits 35..18, address in bits 17..0 |
| amount | input | 18 | Signed adjust amount |
| out_valid | output | 1 | Result pulse, one cycle after in_valid |
| result | output | 36 | Updated word |
| loop_go | output | 1 | Step mode: updated word still negative |
| trap_ovf | output | 1 | Adjust mode: word sign changed |

## Verification
Every output is due in the cycle after the strobe. There is one register stage and no other path. The bench drives each request on a falling edge, waits past the next rising edge, and then compares the word, both flags and out_valid against values from its own functions. Idle cycles are placed between some requests. In those cycles the bench checks that out_valid has dropped and that the word and flags still hold the last result.

// File: rtl/halfword_adjust_unit.sv
module halfword_adjust_unit #(
  parameter int HALF_W = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  op_sel,
  input  logic [2*HALF_W-1:0]   operand,
  input  logic [HALF_W-1:0]     amount,
  output logic                  out_valid,
  output logic [2*HALF_W-1:0]   result,
  output logic                  loop_go,
  output logic                  trap_ovf
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int MSB    = WORD_W - 1;

  logic [HALF_W-1:0] addend;
  logic [HALF_W-1:0] hi_sum, lo_sum;
  logic [WORD_W-1:0] next_word;
  logic              mode_q;

  assign addend    = op_sel ? amount : HALF_W'(1);
  assign hi_sum    = operand[WORD_W-1:HALF_W] + addend;
  assign lo_sum    = operand[HALF_W-1:0] + addend;
  assign next_word = {hi_sum, lo_sum};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      loop_go   <= 1'b0;
      trap_ovf  <= 1'b0;
      mode_q    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= next_word;
        mode_q   <= op_sel;
        loop_go  <= !op_sel && next_word[MSB];
        trap_ovf <= op_sel && (next_word[MSB] != operand[MSB]);
      end
    end
  end

  AST_STEP_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && !$past(op_sel)) |->
      result[HALF_W-1:0] == $past(operand[HALF_W-1:0]) + HALF_W'(1)); // R1
  AST_NO_CROSS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && !$past(op_sel)) |->
      result[WORD_W-1:HALF_W] == $past(operand[WORD_W-1:HALF_W]) + HALF_W'(1)); // R2
  AST_ADJ_HI: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_sel)) |->
      result[WORD_W-1:HALF_W] == $past(operand[WORD_W-1:HALF_W]) + $past(amount)); // R3
  AST_SIGN_TRAP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q) |-> trap_ovf == (result[MSB] != $past(operand[MSB]))); // R5
  AST_STEP_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !mode_q) |-> !trap_ovf && (loop_go == result[MSB])); // R6
  AST_ADJ_NO_LOOP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q) |-> !loop_go); // R6
  AST_PULSE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(result) && $stable(trap_ovf) && $stable(loop_go))); // R8
endmodule

// File: tb/halfword_adjust_unit_bench.sv
`timescale 1ns/1ps
module halfword_adjust_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_sel = 1'b0;
  logic [35:0] operand = '0;
  logic [17:0] amount = '0;
  logic        out_valid, loop_go, trap_ovf;
  logic [35:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  halfword_adjust_unit u_halfword_adjust_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .operand(operand), .amount(amount), .out_valid(out_valid),
    .result(result), .loop_go(loop_go), .trap_ovf(trap_ovf)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [35:0] exp_word(input logic op, input logic [35:0] w, input logic [17:0] e);
    logic [17:0] d;
    logic [17:0] hi;
    logic [17:0] lo;
    d  = op ? e : 18'd1;
    hi = w[35:18] + d;
    lo = w[17:0] + d;
    return {hi, lo};
  endfunction

  function automatic logic exp_loop(input logic op, input logic [35:0] w, input logic [17:0] e);
    logic [35:0] r;
    r = exp_word(op, w, e);
    return !op && r[35];
  endfunction

  function automatic logic exp_trap(input logic op, input logic [35:0] w, input logic [17:0] e);
    logic [35:0] r;
    r = exp_word(op, w, e);
    return op && (r[35] != w[35]);
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %o expected %o", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic op, input logic [35:0] w, input logic [17:0] e);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; operand = w; amount = e;
    @(posedge clk); #5;
    chk({req, " R7 valid"}, {35'd0, out_valid}, 36'd1);
    chk({req, " word"}, result, exp_word(op, w, e));
    chk({req, " R6 loop"}, {35'd0, loop_go}, {35'd0, exp_loop(op, w, e)});
    chk({req, " R5 trap"}, {35'd0, trap_ovf}, {35'd0, exp_trap(op, w, e)});
  endtask

  task automatic idle_check(input logic [35:0] w_prev, input logic lg, input logic tr);
    @(negedge clk);
    in_valid = 1'b0; operand = 36'o123456765432; amount = 18'o777000; op_sel = 1'b1;
    @(posedge clk); #5;
    chk("R7 valid low", {35'd0, out_valid}, 36'd0);
    chk("R8 word hold", result, w_prev);
    chk("R8 flags hold", {34'd0, loop_go, trap_ovf}, {34'd0, lg, tr});
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd4711;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk); #5;
    chk("R9 reset word", result, 36'd0);
    chk("R9 reset flags", {33'd0, out_valid, loop_go, trap_ovf}, 36'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;

    apply("R1 step", 1'b0, 36'o000005_000100, 18'd0);
    apply("R2 low carry", 1'b0, 36'o000003_777777, 18'd0);
    chk("R2 exact", result, 36'o000004_000000);
    apply("R2 high wrap", 1'b0, 36'o777777_000010, 18'd0);
    chk("R2 high exact", result, 36'o000000_000011);
    apply("R6 step negative", 1'b0, 36'o777770_001000, 18'd0);
    chk("R6 loop set", {35'd0, loop_go}, 36'd1);
    idle_check(result, loop_go, trap_ovf);
    apply("R3 adjust", 1'b1, 36'o000010_000200, 18'o000004);
    chk("R3 exact", result, 36'o000014_000204);
    apply("R4 adjust neg", 1'b1, 36'o000010_000200, 18'o777777);
    chk("R4 exact", result, 36'o000007_000177);
    apply("R5 sign flip up", 1'b1, 36'o377776_000000, 18'o000005);
    chk("R5 trap set", {35'd0, trap_ovf}, 36'd1);
    apply("R5 sign flip down", 1'b1, 36'o777776_000000, 18'o000003);
    chk("R5 trap back", {35'd0, trap_ovf}, 36'd1);
    apply("R5 no flip", 1'b1, 36'o777700_000010, 18'o000003);
    chk("R6 adjust loop low", {35'd0, loop_go}, 36'd0);
    apply("R2 adjust low carry", 1'b1, 36'o000001_777776, 18'o000004);
    chk("R2 adjust exact", result, 36'o000005_000002);
    idle_check(result, loop_go, trap_ovf);

    for (int i = 0; i < 300; i++) begin
      logic        op;
      logic [35:0] w;
      logic [17:0] e;
      op = 1'($urandom());
      w  = {4'($urandom()), 32'($urandom())};
      e  = 18'($urandom());
      if (i % 7 == 0) w[17:0] = '1;
      apply(op ? "R3 R4 random adjust" : "R1 random step", op, w, e);
      if (i % 11 == 0) idle_check(result, loop_go, trap_ovf);
    end

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #5;
    chk("R9 late reset", {result[32:0], out_valid, loop_go, trap_ovf}, 36'd0);
    chk("R9 late reset top", {33'd0, result[35:33]}, 36'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule